// File: doc/BRIEF.md
# Aged Circuit Delay Estimator

This block keeps a running estimate of how slow each of several monitored logic circuits has become with age. It does not measure the circuits directly. Ring-oscillator sensors next to each circuit report two delay-shift readings, one for bias-temperature-instability wear and one for hot-carrier wear. Each accepted sample turns into a delay estimate for the named circuit. The estimate is that circuit's reference delay plus the sensor degradation scaled by two per-circuit degradation ratios. Ratios are unsigned Q2.14 fixed point. Delays and readings are 16-bit unsigned values in picoseconds.

At reset, the reference delay of every circuit is its nominal design delay. Its ratios are the presilicon ones, and its sensor baseline is zero. On rare occasions, external software measures a circuit's true delay and fits fresh ratios. It then writes both through the update port. From then on, that circuit's estimates start from the measured delay and use the new ratios. Degradation is counted only from the sensor reading that was current when the update arrived. The ratios do not depend on supply voltage or temperature, so one set per circuit serves every operating point.

Top module: `aged_delay_est`

## Requirements
- R1: After reset, every circuit is uncalibrated (`est_cal`=0). Its reference delay is the nominal delay, and its baselines are zero. The default nominal delays for circuits 0..3 are 900, 1000, 1100 and 1200 ps. The default BTI ratios are 1.5, 1.0, 0.75 and 2.0. The default HCI ratios are 0.5, 0.25, 1.25 and 1.0.
- R2: The estimate is ref + round((kb·dB + kh·dH) / 2^14). Here dB and dH are the current readings minus the circuit's baselines.
- R3: Rounding is half-up: 2^13 is added before the 14-bit shift. A sum above 65535 saturates to 65535.
- R4: An update (index, true delay, kb, kh) replaces that circuit's reference delay and ratios and sets its calibrated flag. Later estimates for it use the new values.
- R5: On an update, the circuit's baselines take the last accepted sensor readings for that circuit. A reading below its baseline contributes zero degradation.
- R6: When an update and a sample for the same circuit arrive in the same cycle, the sample uses the updated delay and ratios. Its baseline is the reading stored before that cycle.
- R7: An update for one circuit leaves the estimates of every other circuit unchanged.
- R8: `smp_ready` is 1 from the first clock after reset, so a sample is taken on every cycle it is offered. `est_valid` pulses for one cycle, two clock edges after the accepting edge, and carries that sample's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sensor sample offered |
| smp_ready | output | 1 | Block can take a sample |
| smp_idx | input | 2 | Circuit the sample belongs to |
| smp_bti | input | 16 | BTI sensor delay reading, ps |
| smp_hci | input | 16 | HCI sensor delay reading, ps |
| upd_valid | input | 1 | Measurement update strobe |
| upd_idx | input | 2 | Circuit being recalibrated |
| upd_delay | input | 16 | Measured true delay, ps |
| upd_kb | input | 16 | New BTI ratio, Q2.14 |
| upd_kh | input | 16 | New HCI ratio, Q2.14 |
| est_valid | output | 1 | Estimate strobe |
| est_idx | output | 2 | Circuit of the estimate |
| est_delay | output | 16 | Estimated delay, ps |
| est_cal | output | 1 | Circuit has had at least one update |

## Verification
Every estimate is due on the second rising edge after the edge that accepted its sample. The table write and the sample capture happen on that first edge, and the multiply-add result is registered on the second. The driver records the cycle count at which each expected estimate must appear. The monitor compares values and that due cycle as each strobe is seen at the falling edge. Update-only cycles produce nothing, so their effect is observed through the next sample for the same circuit and for other circuits.

// File: rtl/est_pkg.sv
package est_pkg;
  localparam int DW   = 16;  // delay / reading width
  localparam int KW   = 16;  // ratio width, Q2.14
  localparam int FRAC = 14;  // fractional bits of a ratio

  // degradation since baseline, floored at zero
  function automatic logic [DW-1:0] shift_since(input logic [DW-1:0] now_v,
                                                input logic [DW-1:0] base_v);
    return (now_v > base_v) ? (now_v - base_v) : '0;
  endfunction
endpackage

// File: rtl/est_table.sv
module est_table
  import est_pkg::*;
#(
  parameter int N_CKT = 4,
  parameter logic [N_CKT*DW-1:0] NOM_DLY = '0,
  parameter logic [N_CKT*KW-1:0] KB_PRE  = '0,
  parameter logic [N_CKT*KW-1:0] KH_PRE  = '0,
  localparam int IW = (N_CKT > 1) ? $clog2(N_CKT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic [IW-1:0] upd_idx,
  input  logic [DW-1:0] upd_delay,
  input  logic [KW-1:0] upd_kb,
  input  logic [KW-1:0] upd_kh,
  input  logic          take,
  input  logic [IW-1:0] rd_idx,
  input  logic [DW-1:0] rd_bti,
  input  logic [DW-1:0] rd_hci,
  output logic [DW-1:0] rd_rdly,
  output logic [KW-1:0] rd_kb,
  output logic [KW-1:0] rd_kh,
  output logic [DW-1:0] rd_base_b,
  output logic [DW-1:0] rd_base_h,
  output logic          rd_cal
);
  logic [DW-1:0] rdly_q [N_CKT], rdly_d [N_CKT];
  logic [KW-1:0] kb_q   [N_CKT], kb_d   [N_CKT];
  logic [KW-1:0] kh_q   [N_CKT], kh_d   [N_CKT];
  logic [DW-1:0] bb_q   [N_CKT], bb_d   [N_CKT];
  logic [DW-1:0] bh_q   [N_CKT], bh_d   [N_CKT];
  logic [DW-1:0] lb_q   [N_CKT], lb_d   [N_CKT];
  logic [DW-1:0] lh_q   [N_CKT], lh_d   [N_CKT];
  logic [N_CKT-1:0] cal_q, cal_d;

  always_comb begin
    for (int i = 0; i < N_CKT; i++) begin
      rdly_d[i] = rdly_q[i];
      kb_d[i]   = kb_q[i];
      kh_d[i]   = kh_q[i];
      bb_d[i]   = bb_q[i];
      bh_d[i]   = bh_q[i];
      lb_d[i]   = lb_q[i];
      lh_d[i]   = lh_q[i];
    end
    cal_d = cal_q;
    if (upd_valid) begin
      rdly_d[upd_idx] = upd_delay;
      kb_d[upd_idx]   = upd_kb;
      kh_d[upd_idx]   = upd_kh;
      bb_d[upd_idx]   = lb_q[upd_idx];
      bh_d[upd_idx]   = lh_q[upd_idx];
      cal_d[upd_idx]  = 1'b1;
    end
    if (take) begin
      lb_d[rd_idx] = rd_bti;
      lh_d[rd_idx] = rd_hci;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CKT; i++) begin
        rdly_q[i] <= NOM_DLY[i*DW +: DW];
        kb_q[i]   <= KB_PRE[i*KW +: KW];
        kh_q[i]   <= KH_PRE[i*KW +: KW];
        bb_q[i]   <= '0;
        bh_q[i]   <= '0;
        lb_q[i]   <= '0;
        lh_q[i]   <= '0;
      end
      cal_q <= '0;
    end else begin
      for (int i = 0; i < N_CKT; i++) begin
        rdly_q[i] <= rdly_d[i];
        kb_q[i]   <= kb_d[i];
        kh_q[i]   <= kh_d[i];
        bb_q[i]   <= bb_d[i];
        bh_q[i]   <= bh_d[i];
        lb_q[i]   <= lb_d[i];
        lh_q[i]   <= lh_d[i];
      end
      cal_q <= cal_d;
    end
  end

  // read port: a same-cycle update to the sampled circuit wins (R6)
  logic hit;
  assign hit       = upd_valid && (upd_idx == rd_idx);
  assign rd_rdly   = hit ? upd_delay : rdly_q[rd_idx];
  assign rd_kb     = hit ? upd_kb    : kb_q[rd_idx];
  assign rd_kh     = hit ? upd_kh    : kh_q[rd_idx];
  assign rd_base_b = hit ? lb_q[rd_idx] : bb_q[rd_idx];
  assign rd_base_h = hit ? lh_q[rd_idx] : bh_q[rd_idx];
  assign rd_cal    = hit | cal_q[rd_idx];

  // R4: an update lands in the addressed entry
  p_upd_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (cal_q[$past(upd_idx)] && rdly_q[$past(upd_idx)] == $past(upd_delay)));

  // R5: the baseline snapshot equals the last reading held before the update
  p_base_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (bb_q[$past(upd_idx)] == $past(lb_q[upd_idx])));
endmodule

// File: rtl/est_mac.sv
module est_mac
  import est_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] in_idx,
  input  logic          in_cal,
  input  logic [DW-1:0] in_rdly,
  input  logic [KW-1:0] in_kb,
  input  logic [KW-1:0] in_kh,
  input  logic [DW-1:0] in_db,
  input  logic [DW-1:0] in_dh,
  output logic          out_valid,
  output logic [IW-1:0] out_idx,
  output logic          out_cal,
  output logic [DW-1:0] out_est
);
  localparam int PW = KW + DW;     // one product
  localparam int SW = PW + 1;      // two products summed
  localparam int RW = SW + 1;      // with rounding constant
  localparam int QW = RW - FRAC;   // after dropping fraction
  localparam int TW = QW + 1;      // with reference delay
  localparam logic [RW-1:0] HALF = RW'(1) << (FRAC - 1);

  logic [PW-1:0] pb, ph;
  logic [SW-1:0] psum;
  logic [RW-1:0] prnd;
  logic [QW-1:0] pq;
  logic [TW-1:0] tot;
  logic [DW-1:0] est_d;

  always_comb begin
    pb    = PW'(in_kb) * PW'(in_db);
    ph    = PW'(in_kh) * PW'(in_dh);
    psum  = SW'(pb) + SW'(ph);
    prnd  = RW'(psum) + HALF;
    pq    = QW'(prnd >> FRAC);
    tot   = TW'(pq) + TW'(in_rdly);
    est_d = (|tot[TW-1:DW]) ? {DW{1'b1}} : tot[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_cal   <= 1'b0;
      out_est   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_idx <= in_idx;
        out_cal <= in_cal;
        out_est <= est_d;
      end
    end
  end

  // R3: saturation never wraps below the reference delay
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_est >= $past(in_rdly)));
endmodule

// File: rtl/aged_delay_est.sv
module aged_delay_est
  import est_pkg::*;
#(
  parameter int N_CKT = 4,
  parameter logic [N_CKT*DW-1:0] NOM_DLY = {16'd1200, 16'd1100, 16'd1000, 16'd900},
  parameter logic [N_CKT*KW-1:0] KB_PRE  = {16'd32768, 16'd12288, 16'd16384, 16'd24576},
  parameter logic [N_CKT*KW-1:0] KH_PRE  = {16'd16384, 16'd20480, 16'd4096, 16'd8192},
  localparam int IW = (N_CKT > 1) ? $clog2(N_CKT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [IW-1:0] smp_idx,
  input  logic [DW-1:0] smp_bti,
  input  logic [DW-1:0] smp_hci,
  input  logic          upd_valid,
  input  logic [IW-1:0] upd_idx,
  input  logic [DW-1:0] upd_delay,
  input  logic [KW-1:0] upd_kb,
  input  logic [KW-1:0] upd_kh,
  output logic          est_valid,
  output logic [IW-1:0] est_idx,
  output logic [DW-1:0] est_delay,
  output logic          est_cal
);
  logic take;
  logic rdy_q;
  logic [DW-1:0] t_rdly, t_bb, t_bh;
  logic [KW-1:0] t_kb, t_kh;
  logic          t_cal;

  assign smp_ready = rdy_q;
  assign take      = smp_valid & rdy_q;

  est_table #(
    .N_CKT(N_CKT), .NOM_DLY(NOM_DLY), .KB_PRE(KB_PRE), .KH_PRE(KH_PRE)
  ) tbl_i (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_delay(upd_delay),
    .upd_kb(upd_kb), .upd_kh(upd_kh),
    .take(take), .rd_idx(smp_idx), .rd_bti(smp_bti), .rd_hci(smp_hci),
    .rd_rdly(t_rdly), .rd_kb(t_kb), .rd_kh(t_kh),
    .rd_base_b(t_bb), .rd_base_h(t_bh), .rd_cal(t_cal)
  );

  // operand stage
  logic          s1_valid_q, s1_valid_d;
  logic [IW-1:0] s1_idx_q, s1_idx_d;
  logic          s1_cal_q, s1_cal_d;
  logic [DW-1:0] s1_rdly_q, s1_rdly_d, s1_db_q, s1_db_d, s1_dh_q, s1_dh_d;
  logic [KW-1:0] s1_kb_q, s1_kb_d, s1_kh_q, s1_kh_d;

  always_comb begin
    s1_valid_d = take;
    s1_idx_d   = s1_idx_q;
    s1_cal_d   = s1_cal_q;
    s1_rdly_d  = s1_rdly_q;
    s1_kb_d    = s1_kb_q;
    s1_kh_d    = s1_kh_q;
    s1_db_d    = s1_db_q;
    s1_dh_d    = s1_dh_q;
    if (take) begin
      s1_idx_d  = smp_idx;
      s1_cal_d  = t_cal;
      s1_rdly_d = t_rdly;
      s1_kb_d   = t_kb;
      s1_kh_d   = t_kh;
      s1_db_d   = shift_since(smp_bti, t_bb);
      s1_dh_d   = shift_since(smp_hci, t_bh);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      s1_valid_q <= 1'b0;
      s1_idx_q   <= '0;
      s1_cal_q   <= 1'b0;
      s1_rdly_q  <= '0;
      s1_kb_q    <= '0;
      s1_kh_q    <= '0;
      s1_db_q    <= '0;
      s1_dh_q    <= '0;
    end else begin
      rdy_q      <= 1'b1;
      s1_valid_q <= s1_valid_d;
      s1_idx_q   <= s1_idx_d;
      s1_cal_q   <= s1_cal_d;
      s1_rdly_q  <= s1_rdly_d;
      s1_kb_q    <= s1_kb_d;
      s1_kh_q    <= s1_kh_d;
      s1_db_q    <= s1_db_d;
      s1_dh_q    <= s1_dh_d;
    end
  end

  est_mac #(.IW(IW)) mac_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s1_valid_q), .in_idx(s1_idx_q), .in_cal(s1_cal_q),
    .in_rdly(s1_rdly_q), .in_kb(s1_kb_q), .in_kh(s1_kh_q),
    .in_db(s1_db_q), .in_dh(s1_dh_q),
    .out_valid(est_valid), .out_idx(est_idx), .out_cal(est_cal), .out_est(est_delay)
  );

  // R8: results arrive exactly two edges after acceptance, with the index
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ##2 est_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> $past(take, 2));
  p_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> (est_idx == $past(smp_idx, 2)));
  p_ready_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> smp_ready);
endmodule

// File: tb/aged_delay_est_tb_top.sv
module aged_delay_est_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid, smp_ready, upd_valid, est_valid, est_cal;
  logic [1:0]  smp_idx, upd_idx, est_idx;
  logic [15:0] smp_bti, smp_hci, upd_delay, upd_kb, upd_kh, est_delay;

  always #2 clk = ~clk;  // 250 MHz

  aged_delay_est dut_i (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_idx(smp_idx),
    .smp_bti(smp_bti), .smp_hci(smp_hci),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_delay(upd_delay),
    .upd_kb(upd_kb), .upd_kh(upd_kh),
    .est_valid(est_valid), .est_idx(est_idx), .est_delay(est_delay), .est_cal(est_cal)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  // reference model state
  int m_rd[4], m_kb[4], m_kh[4], m_bb[4], m_bh[4], m_lb[4], m_lh[4];
  bit m_cal[4];

  // scoreboard
  logic [18:0] exp_q[$];   // {cal, idx, delay}
  int          due_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int floor0(int a, int b);
    return (a > b) ? a - b : 0;
  endfunction

  function automatic logic [15:0] model_est(int i, int b, int h);
    longint p, q, s;
    p = longint'(m_kb[i]) * floor0(b, m_bb[i]) + longint'(m_kh[i]) * floor0(h, m_bh[i]);
    q = (p + 8192) >>> 14;
    s = m_rd[i] + q;
    return (s > 65535) ? 16'hFFFF : 16'(s);
  endfunction

  task automatic chk(string tag, longint act, longint exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, act, exp_v);
    end
  endtask

  // one driven cycle: optional update and optional sample
  task automatic cyc_drive(bit uv, int ui, int ud, int ukb, int ukh,
                           bit sv, int si, int sb, int sh, string tag);
    @(negedge clk);
    upd_valid = uv; upd_idx = 2'(ui); upd_delay = 16'(ud); upd_kb = 16'(ukb); upd_kh = 16'(ukh);
    smp_valid = sv; smp_idx = 2'(si); smp_bti = 16'(sb); smp_hci = 16'(sh);
    if (uv) begin
      m_bb[ui] = m_lb[ui]; m_bh[ui] = m_lh[ui];
      m_rd[ui] = ud; m_kb[ui] = ukb; m_kh[ui] = ukh; m_cal[ui] = 1'b1;
    end
    if (sv) begin
      exp_q.push_back({m_cal[si], 2'(si), model_est(si, sb, sh)});
      due_q.push_back(cyc + 2);
      tag_q.push_back(tag);
      m_lb[si] = sb; m_lh[si] = sh;
    end
  endtask

  task automatic sample(int i, int b, int h, string tag);
    cyc_drive(0, 0, 0, 0, 0, 1, i, b, h, tag);
  endtask

  task automatic update(int i, int d, int kb, int kh);
    cyc_drive(1, i, d, kb, kh, 0, 0, 0, 0, "");
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc_drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && est_valid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected estimate", 1, 0);
      end else begin
        logic [18:0] e;
        int d;
        string t;
        e = exp_q.pop_front(); d = due_q.pop_front(); t = tag_q.pop_front();
        chk({t, " delay"}, est_delay, e[15:0]);
        chk("R8 index", est_idx, e[17:16]);
        chk("R1 R4 calibrated flag", est_cal, e[18]);
        chk("R8 due cycle", cyc, d);
      end
    end
  end

  initial begin
    m_rd = '{900, 1000, 1100, 1200};
    m_kb = '{24576, 16384, 12288, 32768};
    m_kh = '{8192, 4096, 20480, 16384};
    for (int i = 0; i < 4; i++) begin
      m_bb[i] = 0; m_bh[i] = 0; m_lb[i] = 0; m_lh[i] = 0; m_cal[i] = 0;
    end
    rst_n = 1'b0;
    smp_valid = 0; upd_valid = 0; smp_idx = 0; upd_idx = 0;
    smp_bti = 0; smp_hci = 0; upd_delay = 0; upd_kb = 0; upd_kh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 ready after reset", smp_ready, 1);
    chk("R1 no estimate in reset state", est_valid, 0);

    // R1/R2: uncalibrated circuits use nominal delay and presilicon ratios
    sample(0, 100, 40, "R1 circuit0 presilicon");
    // R8 back-to-back on all circuits
    sample(1, 250, 80, "R2 circuit1");
    sample(2, 300, 200, "R2 circuit2");
    sample(3, 50, 10, "R2 circuit3");
    idle(3);
    // R3 rounding: 0.25*2 = 0.5 rounds up, 0.25*1 = 0.25 rounds down
    sample(1, 250, 2, "R3 round half up");
    sample(1, 250, 1, "R3 round down");
    // R3 saturation
    sample(3, 65535, 65535, "R3 saturate");
    idle(3);
    // R4/R5: recalibrate circuit 2; baseline becomes (300,200)
    update(2, 1500, 16384, 8192);
    sample(2, 400, 260, "R4 R5 after update");
    sample(2, 100, 50, "R5 below baseline floors to zero");
    // R7: circuit 1 untouched
    sample(1, 250, 80, "R7 other circuit unchanged");
    idle(2);
    // R6: same-cycle update and sample on circuit 0; baseline is (100,40)
    cyc_drive(1, 0, 1000, 32768, 0, 1, 0, 180, 90, "R6 update before sample");
    sample(0, 200, 90, "R6 follow-up");
    idle(6);
    chk("R8 all estimates delivered", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog expired got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule